// File: doc/BRIEF.md
# Gated Zero-Cross Timestamper with Delayed Converter Trigger

This block timestamps zero crossings of a measured waveform and schedules a converter sample a fixed delay after each crossing. A free-running 16-bit time base advances only while an enable from the measurement sequencer is high. A cycle-start pulse clears it, so every timestamp is measured from the same point of each measurement cycle. The zero-cross input is asynchronous. It is resynchronized, and a rising edge latches the time base into a capture register. The fixed resynchronization latency is subtracted from the latched value.

Every capture fires a one-shot delay generator. Its output stays low for a programmable number of clocks and then high for a short pulse. The rising edge of that output is a single-cycle start strobe to an external converter. The sequencer opens and closes a detect window. Inside the window, timestamps and converter results are stored in two separate buffers, each at an auto-incrementing index that stops at the buffer depth. When the window closes, a done flag is raised and the two entry counts stay frozen for readout through a shared read index.

Top module: `zc_stamp_top`

## Requirements
- R1: The time base is CNT_W (16) bits wide. A high `cycleStart` at a clock edge clears it to 0, and this takes priority over counting. Otherwise it advances by one at each edge with `gateIn` high and holds while `gateIn` is low. It wraps from 65535 to 0.
- R2: `zcIn` goes through a two-flop synchronizer with no filter and no prescaler. A rising edge loads `stamp` with the time base value of the clock cycle in which `zcIn` was first high, assuming `gateIn` was high throughout. `stamp` is taken modulo 2^16.
- R3: `stampValid` is high for exactly one cycle per rising edge of `zcIn`. That cycle follows the second clock edge after the edge that first samples `zcIn` high. `stamp` holds its value until the next capture.
- R4: A `winOpen` pulse sets `winActive`. It also clears `done`, both entry counts and both full flags. A `winClose` pulse while the window is open clears `winActive` and sets `done`. Captures and conversion results outside the window are not stored and leave the counts unchanged.
- R5: Inside the window, each capture writes its timestamp to the stamp buffer at index `stampCount`, and `stampCount` then increments. Once DEPTH (60) entries are stored, `stampFull` is high and further captures are dropped.
- R6: Inside the window, each `convDone` pulse writes `convData` to the result buffer at index `resultCount`, and `resultCount` then increments. The same DEPTH limit applies, with `resultFull` high when it is reached.
- R7: A capture with the one-shot idle starts it. `convStart` is a one-cycle pulse exactly DLY_HI (187) cycles after the `stampValid` cycle. `delayOut` is high from that cycle for DLY_END−DLY_HI (30) cycles. The one-shot is then idle.
- R8: A capture that arrives while the one-shot is running is still timestamped and buffered. It does not restart or extend the delay. It sets the sticky `overrun` flag, which only reset or the next `winOpen` clears.
- R9: `stampRd` and `resultRd` return the buffer entries at `rdIdx` combinationally. When `rdIdx` is DEPTH or above, both return 0.
- R10: After reset, `stamp`, `stampValid`, `delayOut`, `convStart`, `overrun`, `winActive`, `done`, both counts and both full flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateIn | input | 1 | Time base count enable from the sequencer |
| cycleStart | input | 1 | Clears the time base |
| zcIn | input | 1 | Asynchronous zero-cross detector input |
| winOpen | input | 1 | Opens the detect window (pulse) |
| winClose | input | 1 | Closes the detect window (pulse) |
| convDone | input | 1 | Converter end-of-conversion strobe |
| convData | input | RES_W | Converter result |
| rdIdx | input | IDX_W | Buffer read index |
| stamp | output | CNT_W | Last corrected timestamp |
| stampValid | output | 1 | One-cycle capture strobe |
| delayOut | output | 1 | One-shot delay output |
| convStart | output | 1 | Converter start strobe |
| overrun | output | 1 | Sticky capture-during-delay flag |
| winActive | output | 1 | Detect window open |
| done | output | 1 | Window has closed |
| stampCount | output | IDX_W | Timestamps stored |
| resultCount | output | IDX_W | Results stored |
| stampFull | output | 1 | Stamp buffer full |
| resultFull | output | 1 | Result buffer full |
| stampRd | output | CNT_W | Stamp buffer entry at rdIdx |
| resultRd | output | RES_W | Result buffer entry at rdIdx |

## Verification
The bench builds the block with its default parameters: a 16-bit time base, 60-entry buffers, and a 187/217 delay. These values keep the full-buffer limit within reach through a burst of 62 closely spaced crossings. The exact 187-cycle start delay and the 30-cycle pulse are counted edge by edge. Because the counter is 16 bits, a single capture straddling the 65535-to-0 wrap can be placed about 65 thousand cycles after a clear.

// File: rtl/zc_stamp_pkg.sv
package zc_stamp_pkg;
  // write strobes from control to datapath
  typedef struct packed {
    logic stampWe;
    logic resWe;
  } wrStrobe_t;
endpackage

// File: rtl/zc_stamp_oneshot.sv
module zc_stamp_oneshot #(
  parameter int DLY_HI  = 187,
  parameter int DLY_END = 217,
  localparam int DW = $clog2(DLY_END + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic busy,
  output logic level,
  output logic startPulse
);
  logic running;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      dcnt    <= '0;
    end else if (running) begin
      if (dcnt == DW'(DLY_END - 1)) begin
        running <= 1'b0;
        dcnt    <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end else if (fire) begin
      running <= 1'b1;
      dcnt    <= '0;
    end
  end

  assign busy       = running;
  assign level      = running && (dcnt >= DW'(DLY_HI));
  assign startPulse = running && (dcnt == DW'(DLY_HI));
endmodule

// File: rtl/zc_stamp_ctrl.sv
module zc_stamp_ctrl
  import zc_stamp_pkg::*;
#(
  parameter int DEPTH = 60,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             winOpen,
  input  logic             winClose,
  input  logic             riseEv,
  input  logic             convDone,
  input  logic             delayBusy,
  output wrStrobe_t        wr,
  output logic [IDX_W-1:0] stampIdx,
  output logic [IDX_W-1:0] resIdx,
  output logic             winActive,
  output logic             done,
  output logic             overrun,
  output logic             stampFull,
  output logic             resultFull
);
  assign stampFull  = (stampIdx == IDX_W'(DEPTH));
  assign resultFull = (resIdx == IDX_W'(DEPTH));

  always_comb begin
    wr.stampWe = riseEv && winActive && !stampFull;
    wr.resWe   = convDone && winActive && !resultFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winActive <= 1'b0;
      done      <= 1'b0;
      stampIdx  <= '0;
      resIdx    <= '0;
    end else if (winOpen) begin
      winActive <= 1'b1;
      done      <= 1'b0;
      stampIdx  <= '0;
      resIdx    <= '0;
    end else begin
      if (winClose && winActive) begin
        winActive <= 1'b0;
        done      <= 1'b1;
      end
      if (wr.stampWe) stampIdx <= stampIdx + 1'b1;
      if (wr.resWe)   resIdx   <= resIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     overrun <= 1'b0;
    else if (winOpen)              overrun <= 1'b0;
    else if (riseEv && delayBusy)  overrun <= 1'b1;
  end
endmodule

// File: rtl/zc_stamp_dp.sv
module zc_stamp_dp
  import zc_stamp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RES_W       = 16,
  parameter int DEPTH       = 60,
  parameter int IDX_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             cycleStart,
  input  logic             zcIn,
  input  wrStrobe_t        wr,
  input  logic [IDX_W-1:0] stampIdx,
  input  logic [IDX_W-1:0] resIdx,
  input  logic [RES_W-1:0] convData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             riseEv,
  output logic [CNT_W-1:0] stamp,
  output logic             stampValid,
  output logic [CNT_W-1:0] stampRd,
  output logic [RES_W-1:0] resultRd
);
  logic [CNT_W-1:0] timeBase;
  logic [CNT_W-1:0] capVal;
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic [CNT_W-1:0] stampMem [DEPTH];
  logic [RES_W-1:0] resMem [DEPTH];

  // gated time base
  always_ff @(posedge clk) begin
    if (!rstN)           timeBase <= '0;
    else if (cycleStart) timeBase <= '0;
    else if (gateIn)     timeBase <= timeBase + 1'b1;
  end

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= zcIn;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], zcIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign riseEv = syncQ[SYNC_STAGES-1] && !prevQ;
  assign capVal = timeBase - CNT_W'(SYNC_STAGES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stamp      <= '0;
      stampValid <= 1'b0;
    end else begin
      stampValid <= riseEv;
      if (riseEv) stamp <= capVal;
    end
  end

  always_ff @(posedge clk) begin
    if (wr.stampWe) stampMem[stampIdx] <= capVal;
    if (wr.resWe)   resMem[resIdx]     <= convData;
  end

  always_comb begin
    if (rdIdx < IDX_W'(DEPTH)) begin
      stampRd  = stampMem[rdIdx];
      resultRd = resMem[rdIdx];
    end else begin
      stampRd  = '0;
      resultRd = '0;
    end
  end
endmodule

// File: rtl/zc_stamp_top.sv
module zc_stamp_top
  import zc_stamp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RES_W       = 16,
  parameter int DEPTH       = 60,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_HI      = 187,
  parameter int DLY_END     = 217,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             cycleStart,
  input  logic             zcIn,
  input  logic             winOpen,
  input  logic             winClose,
  input  logic             convDone,
  input  logic [RES_W-1:0] convData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] stamp,
  output logic             stampValid,
  output logic             delayOut,
  output logic             convStart,
  output logic             overrun,
  output logic             winActive,
  output logic             done,
  output logic [IDX_W-1:0] stampCount,
  output logic [IDX_W-1:0] resultCount,
  output logic             stampFull,
  output logic             resultFull,
  output logic [CNT_W-1:0] stampRd,
  output logic [RES_W-1:0] resultRd
);
  wrStrobe_t wr;
  logic riseEv;
  logic delayBusy;

  zc_stamp_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .winOpen(winOpen), .winClose(winClose),
    .riseEv(riseEv), .convDone(convDone), .delayBusy(delayBusy), .wr(wr),
    .stampIdx(stampCount), .resIdx(resultCount), .winActive(winActive),
    .done(done), .overrun(overrun), .stampFull(stampFull), .resultFull(resultFull)
  );

  zc_stamp_dp #(
    .CNT_W(CNT_W), .RES_W(RES_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .cycleStart(cycleStart),
    .zcIn(zcIn), .wr(wr), .stampIdx(stampCount), .resIdx(resultCount),
    .convData(convData), .rdIdx(rdIdx), .riseEv(riseEv), .stamp(stamp),
    .stampValid(stampValid), .stampRd(stampRd), .resultRd(resultRd)
  );

  zc_stamp_oneshot #(.DLY_HI(DLY_HI), .DLY_END(DLY_END)) uShot (
    .clk(clk), .rstN(rstN), .fire(riseEv), .busy(delayBusy),
    .level(delayOut), .startPulse(convStart)
  );
endmodule

// File: rtl/zc_stamp_chk.sv
module zc_stamp_chk #(
  parameter int DEPTH = 60,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             winOpen,
  input logic             stampValid,
  input logic             delayOut,
  input logic             convStart,
  input logic             overrun,
  input logic             winActive,
  input logic             done,
  input logic [IDX_W-1:0] stampCount,
  input logic [IDX_W-1:0] resultCount,
  input logic             stampFull
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stampValid |=> !stampValid); // R3
  AST_START_RISES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> delayOut && !$past(delayOut)); // R7
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart && delayOut); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stampCount <= IDX_W'(DEPTH)) && (resultCount <= IDX_W'(DEPTH))); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    stampFull && !winOpen |=> $stable(stampCount)); // R5
  AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !winActive && !winOpen |=> $stable(stampCount) && $stable(resultCount)); // R4
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !winActive); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !winOpen |=> overrun); // R8
endmodule

bind zc_stamp_top zc_stamp_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .winOpen(winOpen), .stampValid(stampValid),
  .delayOut(delayOut), .convStart(convStart), .overrun(overrun),
  .winActive(winActive), .done(done), .stampCount(stampCount),
  .resultCount(resultCount), .stampFull(stampFull)
);

// File: tb/sim_zc_stamp_top.sv
module sim_zc_stamp_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int RES_W = 16;
  localparam int DEPTH = 60;
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int DLY_HI = 187;
  localparam int DLY_END = 217;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateIn = 1'b0, cycleStart = 1'b0, zcIn = 1'b0;
  logic winOpen = 1'b0, winClose = 1'b0, convDone = 1'b0;
  logic [RES_W-1:0] convData = '0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [CNT_W-1:0] stamp, stampRd;
  logic [RES_W-1:0] resultRd;
  logic stampValid, delayOut, convStart, overrun, winActive, done;
  logic stampFull, resultFull;
  logic [IDX_W-1:0] stampCount, resultCount;

  int checks = 0;
  int fails = 0;
  logic [CNT_W-1:0] mCnt;
  logic [CNT_W-1:0] expQ [64];

  zc_stamp_top u0 (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .cycleStart(cycleStart),
    .zcIn(zcIn), .winOpen(winOpen), .winClose(winClose), .convDone(convDone),
    .convData(convData), .rdIdx(rdIdx), .stamp(stamp), .stampValid(stampValid),
    .delayOut(delayOut), .convStart(convStart), .overrun(overrun),
    .winActive(winActive), .done(done), .stampCount(stampCount),
    .resultCount(resultCount), .stampFull(stampFull), .resultFull(resultFull),
    .stampRd(stampRd), .resultRd(resultRd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // time base model built from R1
  always @(posedge clk) begin
    if (!rstN)           mCnt <= '0;
    else if (cycleStart) mCnt <= '0;
    else if (gateIn)     mCnt <= mCnt + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic zcPulse(output logic [CNT_W-1:0] e);
    @(negedge clk);
    zcIn = 1'b1;
    e = mCnt;
    repeat (2) @(negedge clk);
    zcIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic convPulse(input logic [RES_W-1:0] v);
    @(negedge clk);
    convDone = 1'b1;
    convData = v;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic pulseOpen();
    @(negedge clk); winOpen = 1'b1;
    @(negedge clk); winOpen = 1'b0;
  endtask

  task automatic pulseClose();
    @(negedge clk); winClose = 1'b1;
    @(negedge clk); winClose = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(stamp == 0 && !stampValid, "R10", "stamp after reset", stamp, 0);
    chk(!delayOut && !convStart && !overrun, "R10", "delay/overrun after reset",
        {delayOut, convStart, overrun}, 0);
    chk(!winActive && !done && stampCount == 0 && resultCount == 0 && !stampFull && !resultFull,
        "R10", "window state after reset", {winActive, done, stampCount, resultCount}, 0);
  endtask

  task automatic testCapture();
    logic [CNT_W-1:0] e;
    @(negedge clk); gateIn = 1'b1; cycleStart = 1'b1;
    @(negedge clk); cycleStart = 1'b0; zcIn = 1'b1; e = mCnt;
    repeat (2) @(negedge clk);
    zcIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(stamp == 0, "R1", "stamp right after clear", stamp, 0);
    repeat (300) @(negedge clk);
    zcPulse(e);
    chk(stamp == e, "R2", "stamp with gate high", stamp, e);
    repeat (300) @(negedge clk);
    gateIn = 1'b0;
    repeat (50) @(negedge clk);
    gateIn = 1'b1;
    repeat (5) @(negedge clk);
    zcPulse(e);
    chk(stamp == e, "R1", "stamp after gate hold", stamp, e);
    chk(stampCount == 0, "R4", "no storing outside window", stampCount, 0);
    repeat (300) @(negedge clk);
  endtask

  task automatic testDelay();
    int k0 = -1, kc = -1, nStart = 0, nValid = 0, nHi = 0;
    logic [CNT_W-1:0] e;
    @(negedge clk); zcIn = 1'b1; e = mCnt;
    for (int k = 0; k < 320; k++) begin
      if (k == 2) zcIn = 1'b0;
      if (stampValid) begin nValid++; k0 = k; end
      if (convStart) begin nStart++; kc = k; end
      if (delayOut) nHi++;
      @(negedge clk);
    end
    chk(nValid == 1, "R3", "stampValid count", nValid, 1);
    chk(k0 == 3, "R3", "stampValid cycle", k0, 3);
    chk(stamp == e, "R2", "stamp of delay test", stamp, e);
    chk(nStart == 1, "R7", "convStart count", nStart, 1);
    chk(kc - k0 == DLY_HI, "R7", "start delay", kc - k0, DLY_HI);
    chk(nHi == DLY_END - DLY_HI, "R7", "delay pulse width", nHi, DLY_END - DLY_HI);
    chk(!overrun, "R8", "no overrun on idle capture", overrun, 0);
  endtask

  task automatic testOverrun();
    int k0 = -1, kc = -1, nStart = 0;
    logic [CNT_W-1:0] e2;
    @(negedge clk); zcIn = 1'b1;
    for (int k = 0; k < 320; k++) begin
      if (k == 2) zcIn = 1'b0;
      if (k == 20) begin zcIn = 1'b1; e2 = mCnt; end
      if (k == 22) zcIn = 1'b0;
      if (stampValid && k0 < 0) k0 = k;
      if (convStart) begin nStart++; kc = k; end
      if (k == 19) chk(!overrun, "R8", "overrun before second capture", overrun, 0);
      @(negedge clk);
    end
    chk(overrun, "R8", "overrun set", overrun, 1);
    chk(stamp == e2, "R8", "second capture still stamped", stamp, e2);
    chk(nStart == 1, "R8", "no restart of delay", nStart, 1);
    chk(kc - k0 == DLY_HI, "R8", "delay timed from first capture", kc - k0, DLY_HI);
    repeat (10) @(negedge clk);
    chk(overrun, "R8", "overrun sticky", overrun, 1);
  endtask

  task automatic testWindow();
    logic [CNT_W-1:0] e;
    logic [CNT_W-1:0] heldStamp;
    pulseOpen();
    chk(winActive && !done && stampCount == 0 && resultCount == 0, "R4", "window opened",
        {winActive, done}, 2);
    chk(!overrun, "R8", "overrun cleared by open", overrun, 0);
    for (int i = 0; i < 5; i++) begin
      zcPulse(e);
      expQ[i] = e;
      repeat (3) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) convPulse(RES_W'(16'h0100 + i));
    pulseClose();
    chk(done && !winActive, "R4", "window closed", {done, winActive}, 2);
    chk(stampCount == 5, "R5", "stamp count", stampCount, 5);
    chk(resultCount == 4, "R6", "result count", resultCount, 4);
    for (int i = 0; i < 5; i++) begin
      rdIdx = IDX_W'(i);
      #1;
      chk(stampRd == expQ[i], "R5", "stamp entry", stampRd, expQ[i]);
    end
    for (int i = 0; i < 4; i++) begin
      rdIdx = IDX_W'(i);
      #1;
      chk(resultRd == RES_W'(16'h0100 + i), "R6", "result entry", resultRd, 16'h0100 + i);
    end
    rdIdx = IDX_W'(0);
    heldStamp = expQ[0];
    zcPulse(e);
    convPulse(16'hBEEF);
    repeat (3) @(negedge clk);
    chk(stampCount == 5 && resultCount == 4, "R4", "counts frozen after close",
        {stampCount, resultCount}, {IDX_W'(5), IDX_W'(4)});
    #1;
    chk(stampRd == heldStamp, "R4", "entry 0 unchanged after close", stampRd, heldStamp);
    repeat (300) @(negedge clk);
  endtask

  task automatic testFull();
    logic [CNT_W-1:0] e;
    pulseOpen();
    chk(!stampFull && !resultFull, "R4", "full flags cleared on open", {stampFull, resultFull}, 0);
    for (int i = 0; i < 62; i++) begin
      zcPulse(e);
      expQ[i] = e;
    end
    for (int i = 0; i < 61; i++) convPulse(RES_W'(i + 7));
    pulseClose();
    chk(stampCount == IDX_W'(DEPTH) && stampFull, "R5", "stamp buffer full", stampCount, DEPTH);
    chk(resultCount == IDX_W'(DEPTH) && resultFull, "R6", "result buffer full", resultCount, DEPTH);
    rdIdx = IDX_W'(DEPTH - 1);
    #1;
    chk(stampRd == expQ[DEPTH-1], "R5", "last stamp entry", stampRd, expQ[DEPTH-1]);
    chk(resultRd == RES_W'(DEPTH - 1 + 7), "R6", "last result entry", resultRd, DEPTH - 1 + 7);
    rdIdx = IDX_W'(DEPTH);
    #1;
    chk(stampRd == 0 && resultRd == 0, "R9", "read beyond depth", {stampRd, resultRd}, 0);
    rdIdx = '0;
    repeat (300) @(negedge clk);
  endtask

  task automatic testWrap();
    logic [CNT_W-1:0] e;
    @(negedge clk); cycleStart = 1'b1;
    @(negedge clk); cycleStart = 1'b0;
    while (mCnt != 16'hFFFE) @(negedge clk);
    zcIn = 1'b1; e = mCnt;
    repeat (2) @(negedge clk);
    zcIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(stamp == 16'hFFFE && e == 16'hFFFE, "R1", "stamp across wrap", stamp, 16'hFFFE);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCapture();
    testDelay();
    testOverrun();
    testWindow();
    testFull();
    testWrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule